// File: doc/BRIEF.md
# SD Card Command-Line Initialisation Responder

This block acts as the card end of an SD command line. It lets a host controller be brought up without a real card attached. Host command tokens arrive serially on `cmd_i`. Each token is framed, checked against its CRC7 and decoded. The block then steps through the card initialisation handshake.

Three commands get an answer:

- CMD8 is answered with an interface-condition response.
- ACMD41 is answered with an operating-conditions response.
- CMD2 is answered with the 136-bit card-identification response.

Responses leave the block as a data bit (`cmd_o`) and an enable (`cmd_oe_o`), which the surrounding pad logic combines into the open line.

The identification fields arrive on a port, and the block computes their CRC7 itself. After the identification response is fully sent, `init_done_o` is raised. A reset command returns the handshake to its start at any time.

Top module: `sd_init_responder`

## Requirements
- R1: While `rst_ni` is low, `cmd_oe_o` is 0, `cmd_o` is 1, `init_done_o` is 0 and `cmd_err_o` is 0.
- R2: A host token is accepted only in one form.
  - Its bits, in order: a 0 start bit, a 1 transmission bit, a 6-bit index, a 32-bit argument (both MSB first), 7 CRC bits, then a 1 end bit.
  - The CRC must equal the CRC7 of the first 40 bits.
  - If the CRC or the end bit is wrong, the token is dropped without a response and `cmd_err_o` is set. `cmd_err_o` stays set until a token is accepted.
- R3: Responses follow a fixed order.
  - Index 0 gets no response. Index 8 gets the R7 reply, index 55 gets no response, index 41 gets the R3 reply, and index 2 gets the R2 reply.
  - An accepted token whose index is not the one expected next (including any index before the first index-0 token, and any non-zero index after the R2 reply) gets no response and leaves the sequence where it was.
- R4: An accepted index-0 token at any point restarts the sequence, so that index 8 is expected next. It also clears `init_done_o`.
- R5: If the host end bit is sampled on rising edge k, the response start bit is on `cmd_o`, with `cmd_oe_o` high, from rising edge k+NCR_CYCLES (default 2).
- R6: A response is driven one bit per clock, MSB first, with `cmd_oe_o` high for exactly the frame length (48 or 136 bits). On the next edge `cmd_oe_o` falls and `cmd_o` returns to 1.
- R7: The R7 reply is, in order:
  - bits 0, 0;
  - index 001000;
  - 20 zero bits;
  - the received argument bits 11..0;
  - the CRC7 of the preceding 40 bits;
  - a 1.
- R8: The R3 reply is, in order:
  - bits 0, 0;
  - index 111111;
  - a 32-bit OCR in which bit 31 (power-up done) is 1, bit 30 is `ccs_i`, bits 23..15 are all ones and all other bits are 0;
  - seven 1 bits;
  - a 1.
- R9: The R2 reply is, in order:
  - bits 0, 0;
  - index 111111;
  - CID bits 127 down to 1;
  - a 1.

  CID bits 127..8 are taken from `cid_fields_i[119:0]`, except that CID bits 23..20 (`cid_fields_i[15:12]`) are forced to 0. CID bits 7..1 hold the CRC7 of CID bits 127..8.
- R10: The CRC7 register starts at 0. Bits are fed in MSB first. For each bit, the register shifts left, and when the old bit 6 differs from the incoming bit, it is then XORed with 0x09 (polynomial x^7+x^3+1).
- R11: `init_done_o` rises on the same edge on which `cmd_oe_o` falls after the R2 reply.
- R12: `cmd_i` is ignored from the acceptance of a token that is answered until the line is released. A complete valid token sent in that window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Sampled command line |
| cid_fields_i | input | 120 | CID bits 127..8 (bits 15..12 ignored) |
| ccs_i | input | 1 | Capacity status bit placed in the OCR |
| cmd_o | output | 1 | Command line drive value |
| cmd_oe_o | output | 1 | Command line drive enable |
| init_done_o | output | 1 | Identification response completed |
| cmd_err_o | output | 1 | Last rejected token had a bad CRC or end bit |

## Verification
The hardest state to reach from the ports is a complete, valid host token arriving while a reply is still on the line. Only this case shows whether the receiver is really masked during the response. The bench runs the whole handshake up to CMD2, waits for `cmd_oe_o` to rise, and in a concurrent thread sends a well-formed reset token during the 136-bit reply. It then checks that the reply is intact, that `init_done_o` still rises, and that a later CMD8 is still ignored. Out-of-order indices and corrupted CRC or end bits are placed between valid steps, so that each one's lack of effect shows up in the response to the next token.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;
  localparam int FRAME_W = 136;
  localparam int SHORT_W = 48;
  localparam int CID_W   = 120;
  localparam int CRC_W   = 7;
  localparam int IDX_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {RSP_R7, RSP_R3, RSP_R2} rsp_kind_e;

  // one serial CRC7 step, poly x^7+x^3+1
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    return {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ b) ? 7'h09 : 7'h00);
  endfunction
endpackage

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_resp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       cmd_i,
  output logic       valid_o,
  output logic       err_o,
  output logic [5:0] index_o,
  output logic [11:0] echo_o
);
  localparam int BODY_BITS = 46;           // index, argument, crc, end
  localparam int CRC_AT    = 38;           // body bit where crc field starts
  localparam int LAST      = BODY_BITS - 1;
  localparam int CNT_W     = $clog2(BODY_BITS);

  typedef enum logic [1:0] {RX_IDLE, RX_TRANS, RX_BODY} rx_st_e;

  rx_st_e               st_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [BODY_BITS-2:0] sr_q;
  logic [CRC_W-1:0]     crc_q;
  logic                 at_end, good;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sr_q  <= '0;
      crc_q <= '0;
    end else if (!en_i) begin
      st_q <= RX_IDLE;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          crc_q <= '0;
          if (!cmd_i) st_q <= RX_TRANS;
        end
        RX_TRANS: begin
          if (cmd_i) begin
            st_q  <= RX_BODY;
            cnt_q <= '0;
            crc_q <= crc7_step(crc_q, 1'b1);
          end else begin
            st_q <= RX_IDLE;
          end
        end
        default: begin
          sr_q  <= {sr_q[BODY_BITS-3:0], cmd_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < CNT_W'(CRC_AT)) crc_q <= crc7_step(crc_q, cmd_i);
          if (cnt_q == CNT_W'(LAST)) st_q <= RX_IDLE;
        end
      endcase
    end
  end

  assign at_end  = en_i && (st_q == RX_BODY) && (cnt_q == CNT_W'(LAST));
  assign good    = cmd_i && (crc_q == sr_q[CRC_W-1:0]);
  assign valid_o = at_end && good;
  assign err_o   = at_end && !good;
  assign index_o = sr_q[BODY_BITS-2 -: 6];
  assign echo_o  = sr_q[CRC_W +: 12];

  // R2
  // tok_end_chk
  tok_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || err_o) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/sd_rsp_tx.sv
module sd_rsp_tx
  import sd_resp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  rsp_kind_e          kind_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               cmd_o,
  output logic               oe_o,
  output logic               busy_o,
  output logic               last_o
);
  rsp_kind_e          kind_q;
  logic               busy_q, oe_q, cmd_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] sr_q;
  logic [CRC_W-1:0]   crc_q, crc_nxt;
  logic [IDX_W-1:0]   len_m1, acc_lo, acc_hi, sub_hi;
  logic               use_crc, in_acc, in_sub, out_bit;

  always_comb begin
    len_m1  = IDX_W'(SHORT_W - 1);
    acc_lo  = '0;
    acc_hi  = IDX_W'(SHORT_W - 8);
    use_crc = 1'b1;
    case (kind_q)
      RSP_R3: use_crc = 1'b0;        // fixed all-ones crc field in frame
      RSP_R2: begin
        len_m1 = IDX_W'(FRAME_W - 1);
        acc_lo = IDX_W'(8);
        acc_hi = IDX_W'(8 + CID_W);
      end
      default: ;
    endcase
    sub_hi  = acc_hi + IDX_W'(CRC_W);
    in_acc  = use_crc && (idx_q >= acc_lo) && (idx_q < acc_hi);
    in_sub  = use_crc && (idx_q >= acc_hi) && (idx_q < sub_hi);
    out_bit = in_sub ? crc_q[CRC_W-1] : sr_q[FRAME_W-1];
    crc_nxt = in_acc ? crc7_step(crc_q, sr_q[FRAME_W-1]) :
              in_sub ? {crc_q[CRC_W-2:0], 1'b0} : crc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= RSP_R7;
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      cmd_q  <= 1'b1;
      idx_q  <= '0;
      sr_q   <= '0;
      crc_q  <= '0;
    end else if (start_i) begin
      kind_q <= kind_i;
      busy_q <= 1'b1;
      idx_q  <= '0;
      sr_q   <= frame_i;
      crc_q  <= '0;
    end else if (busy_q) begin
      cmd_q <= out_bit;
      oe_q  <= 1'b1;
      sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
      crc_q <= crc_nxt;
      idx_q <= idx_q + 1'b1;
      if (idx_q == len_m1) busy_q <= 1'b0;
    end else begin
      oe_q  <= 1'b0;
      cmd_q <= 1'b1;
    end
  end

  assign cmd_o  = cmd_q;
  assign oe_o   = oe_q;
  assign busy_o = busy_q;
  assign last_o = oe_q && !busy_q;

  // R6
  // frame_oe_chk
  frame_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> oe_q);

  // R6
  // release_chk
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && !busy_q) |=> (!oe_q && cmd_q));
endmodule

// File: rtl/sd_init_responder.sv
module sd_init_responder
  import sd_resp_pkg::*;
#(
  parameter int NCR_CYCLES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic [CID_W-1:0] cid_fields_i,
  input  logic             ccs_i,
  output logic             cmd_o,
  output logic             cmd_oe_o,
  output logic             init_done_o,
  output logic             cmd_err_o
);
  localparam int WAIT_W = (NCR_CYCLES > 2) ? $clog2(NCR_CYCLES) : 1;
  localparam int PAD_W  = FRAME_W - SHORT_W;
  localparam logic [CID_W-1:0] RSV_MASK = CID_W'(16'hF000);  // CID bits 23..20

  typedef enum logic [2:0] {SEQ_WAIT0, SEQ_WAIT8, SEQ_WAIT55, SEQ_WAIT41,
                            SEQ_WAIT2, SEQ_DONE} seq_e;

  seq_e               seq_q, seq_nxt;
  rsp_kind_e          kind_q, kind_nxt;
  logic               rsp_req, pend_q, done_q, err_q, tx_start;
  logic [WAIT_W-1:0]  wcnt_q;
  logic [11:0]        echo_q;
  logic               rx_en, rx_valid, rx_err;
  logic [5:0]         rx_index;
  logic [11:0]        rx_echo;
  logic               tx_busy, tx_oe, tx_last, tx_cmd;
  logic [FRAME_W-1:0] frame;
  logic [31:0]        ocr;
  logic [CID_W-1:0]   cid_m;

  assign rx_en = !pend_q && !tx_busy && !tx_oe;

  sd_cmd_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en),
    .cmd_i   (cmd_i),
    .valid_o (rx_valid),
    .err_o   (rx_err),
    .index_o (rx_index),
    .echo_o  (rx_echo)
  );

  always_comb begin
    seq_nxt  = seq_q;
    rsp_req  = 1'b0;
    kind_nxt = RSP_R7;
    case (seq_q)
      SEQ_WAIT8:  if (rx_index == 6'd8)  begin seq_nxt = SEQ_WAIT55; rsp_req = 1'b1; end
      SEQ_WAIT55: if (rx_index == 6'd55) seq_nxt = SEQ_WAIT41;
      SEQ_WAIT41: if (rx_index == 6'd41) begin seq_nxt = SEQ_WAIT2; rsp_req = 1'b1; kind_nxt = RSP_R3; end
      SEQ_WAIT2:  if (rx_index == 6'd2)  begin seq_nxt = SEQ_DONE; rsp_req = 1'b1; kind_nxt = RSP_R2; end
      default: ;
    endcase
    if (rx_index == 6'd0) begin
      seq_nxt = SEQ_WAIT8;
      rsp_req = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SEQ_WAIT0;
      kind_q <= RSP_R7;
      pend_q <= 1'b0;
      wcnt_q <= '0;
      echo_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (rx_err) err_q <= 1'b1;
      if (rx_valid) begin
        err_q <= 1'b0;
        seq_q <= seq_nxt;
        if (rx_index == 6'd0) done_q <= 1'b0;
        if (rsp_req) begin
          pend_q <= 1'b1;
          wcnt_q <= WAIT_W'(NCR_CYCLES - 2);
          kind_q <= kind_nxt;
          echo_q <= rx_echo;
        end
      end else if (pend_q) begin
        if (wcnt_q == '0) pend_q <= 1'b0;
        else wcnt_q <= wcnt_q - 1'b1;
      end
      if (tx_last && kind_q == RSP_R2) done_q <= 1'b1;
    end
  end

  assign tx_start = pend_q && (wcnt_q == '0);
  assign ocr      = {1'b1, ccs_i, 6'd0, 9'h1FF, 15'd0};
  assign cid_m    = cid_fields_i & ~RSV_MASK;

  always_comb begin
    case (kind_q)
      RSP_R3:  frame = {2'b00, 6'h3F, ocr, 7'h7F, 1'b1, {PAD_W{1'b0}}};
      RSP_R2:  frame = {2'b00, 6'h3F, cid_m, 7'd0, 1'b1};
      default: frame = {2'b00, 6'd8, 20'd0, echo_q, 7'd0, 1'b1, {PAD_W{1'b0}}};
    endcase
  end

  sd_rsp_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_start),
    .kind_i  (kind_q),
    .frame_i (frame),
    .cmd_o   (tx_cmd),
    .oe_o    (tx_oe),
    .busy_o  (tx_busy),
    .last_o  (tx_last)
  );

  assign cmd_o       = tx_cmd;
  assign cmd_oe_o    = tx_oe;
  assign init_done_o = done_q;
  assign cmd_err_o   = err_q;

  // R3
  // seq_hold_chk
  seq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seq_q) |-> $past(rx_valid));

  // R12
  // single_rsp_chk
  single_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start |-> (!tx_busy && !tx_oe));

  // R4
  // done_clear_chk
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(rx_valid && rx_index == 6'd0));

  // R11
  // done_rise_chk
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(tx_last && kind_q == RSP_R2));
endmodule

// File: tb/sim_sd_init_responder.sv
`timescale 1ns/1ps
module sim_sd_init_responder;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         cmd_i;
  logic [119:0] cid_fields_i;
  logic         ccs_i;
  logic         cmd_o, cmd_oe_o, init_done_o, cmd_err_o;

  int checks = 0;
  int fails  = 0;

  int           cw, cn;
  logic [135:0] cb;
  logic         dl, da, rel_ok;

  always #5 clk_i = ~clk_i;

  sd_init_responder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .cid_fields_i(cid_fields_i),
    .ccs_i(ccs_i), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe_o),
    .init_done_o(init_done_o), .cmd_err_o(cmd_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R10 reference: MSB first, poly 0x89
  function automatic logic [6:0] crc_msb(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--)
      c = (c[6] != v[i]) ? ({c[5:0], 1'b0} ^ 7'h09) : {c[5:0], 1'b0};
    return c;
  endfunction

  function automatic logic [135:0] exp_r7(input logic [31:0] arg);
    logic [39:0] p = {2'b00, 6'd8, 20'd0, arg[11:0]};
    return {88'd0, p, crc_msb({96'd0, p}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] exp_r3(input logic ccs);
    return {88'd0, 2'b00, 6'h3F, 1'b1, ccs, 6'd0, 9'h1FF, 15'd0, 7'h7F, 1'b1};
  endfunction

  function automatic logic [135:0] exp_r2(input logic [119:0] f);
    logic [119:0] m = f;
    m[15:12] = 4'd0;
    return {2'b00, 6'h3F, m, crc_msb({16'd0, m}, 120), 1'b1};
  endfunction

  task automatic drive_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input bit bad_crc, input bit bad_end);
    logic [39:0] h = {2'b01, idx, arg};
    logic [6:0]  c = crc_msb({96'd0, h}, 40);
    logic [47:0] t;
    if (bad_crc) c = c ^ 7'h01;
    t = {h, c, ~bad_end};
    for (int i = 47; i >= 0; i--) begin
      @(negedge clk_i);
      cmd_i = t[i];
    end
    if (bad_end) begin
      @(negedge clk_i);
      cmd_i = 1'b1;
    end
  endtask

  task automatic capture();
    cw = 0; cn = 0; cb = '0; dl = 1'b0; da = 1'b0; rel_ok = 1'b0;
    do begin
      @(negedge clk_i);
      cw++;
    end while (!cmd_oe_o && cw < 12);
    if (cmd_oe_o) begin
      while (cmd_oe_o && cn < 200) begin
        cb = {cb[134:0], cmd_o};
        cn++;
        dl = init_done_o;
        @(negedge clk_i);
      end
      da = init_done_o;
      rel_ok = (cmd_o == 1'b1);
    end
  endtask

  task automatic expect_rsp(input string req, input logic [135:0] exp, input int len);
    capture();
    chk(cw == 3, "R5", "turnaround", cw, 3);
    chk(cn == len, "R6", "frame length", cn, len);
    chk(cb == exp, req, "frame bits (R10 crc)", cb, exp);
    chk(rel_ok, "R6", "line released high", rel_ok, 1);
  endtask

  task automatic expect_silent(input string req);
    capture();
    chk(cn == 0, req, "no response", cn, 0);
  endtask

  task automatic t_reset();
    chk(cmd_oe_o == 0 && cmd_o == 1 && init_done_o == 0 && cmd_err_o == 0, "R1",
        "reset outputs", {cmd_oe_o, cmd_o, init_done_o, cmd_err_o}, 4'b0100);
  endtask

  task automatic t_before_cmd0();
    drive_cmd(6'd8, 32'h1AA, 0, 0);
    expect_silent("R3");
  endtask

  task automatic t_bad_frames();
    drive_cmd(6'd0, 32'd0, 1, 0);
    expect_silent("R2");
    chk(cmd_err_o == 1, "R2", "crc error flag", cmd_err_o, 1);
    // CMD0 was dropped, so CMD8 is still out of order
    drive_cmd(6'd8, 32'h1AA, 0, 0);
    expect_silent("R2");
    chk(cmd_err_o == 0, "R2", "flag cleared by accepted token", cmd_err_o, 0);
    drive_cmd(6'd0, 32'd0, 0, 1);
    expect_silent("R2");
    chk(cmd_err_o == 1, "R2", "end bit error flag", cmd_err_o, 1);
  endtask

  task automatic t_init();
    drive_cmd(6'd0, 32'd0, 0, 0);
    expect_silent("R4");
    drive_cmd(6'd8, 32'h0000_01AA, 0, 0);
    expect_rsp("R7", exp_r7(32'h0000_01AA), 48);
    drive_cmd(6'd2, 32'd0, 0, 0);
    expect_silent("R3");
    drive_cmd(6'd55, 32'd0, 0, 0);
    expect_silent("R3");
    drive_cmd(6'd41, 32'h40FF_8000, 0, 0);
    expect_rsp("R8", exp_r3(ccs_i), 48);
    drive_cmd(6'd8, 32'h1AA, 0, 0);
    expect_silent("R3");
    drive_cmd(6'd2, 32'd0, 0, 0);
    expect_rsp("R9", exp_r2(cid_fields_i), 136);
    chk(dl == 0 && da == 1, "R11", "done rises with release", {dl, da}, 2'b01);
  endtask

  task automatic t_restart();
    drive_cmd(6'd0, 32'd0, 0, 0);
    expect_silent("R4");
    chk(init_done_o == 0, "R4", "done cleared", init_done_o, 0);
    drive_cmd(6'd8, 32'h0000_0F5C, 0, 0);
    expect_rsp("R7", exp_r7(32'h0000_0F5C), 48);
    drive_cmd(6'd55, 32'd0, 0, 0);
    expect_silent("R3");
    ccs_i = 1'b0;
    drive_cmd(6'd41, 32'd0, 0, 0);
    expect_rsp("R8", exp_r3(1'b0), 48);
    cid_fields_i = {8'hC3, 16'h5A17, 40'h0F1E2D3C4B, 8'h96, 32'h8765_4321, 4'hF, 12'hABC};
    drive_cmd(6'd2, 32'd0, 0, 0);
    fork
      capture();
      begin
        wait (cmd_oe_o);
        drive_cmd(6'd0, 32'd0, 0, 0);
      end
    join
    chk(cn == 136, "R12", "frame length with token on line", cn, 136);
    chk(cb == exp_r2(cid_fields_i), "R9", "R2 bits, reserved zeroed", cb, exp_r2(cid_fields_i));
    chk(da == 1, "R12", "reset token during reply ignored", da, 1);
    drive_cmd(6'd8, 32'h1AA, 0, 0);
    expect_silent("R3");
    chk(init_done_o == 1, "R12", "done still set", init_done_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    cmd_i = 1'b1;
    ccs_i = 1'b1;
    cid_fields_i = {8'h1D, 16'h4144, 40'h5344_4331_36, 8'h10, 32'hDEAD_BEEF, 4'h0, 12'h0C7};
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_before_cmd0();
    t_bad_frames();
    t_init();
    t_restart();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule